// File: doc/BRIEF.md
# Half-Bridge Gate Drive Sequencer

This block turns a decoded three-level PWM command and a separate low-side keep input into the two gate enables of a synchronous buck half-bridge. It makes sure that a switch is turned on only after the opposite switch reports, through a feedback input, that it has stopped conducting, and only after a further programmable number of cycles has passed. A switch is turned off on the clock edge where that decision is made.

In the middle PWM level the block runs diode emulation. The high side is off. The low side turns on through the non-overlap path and stays on for a blanking window. After the window it is released at the first sampled zero-cross flag and then stays off while the mid command remains. An enable input driven low, or a thermal fault, forces both gates off. Analog decoding of the PWM pin, the comparators and the gate drive itself are outside the block. They appear here as digital inputs.

Top module: `hb_gate_sequencer`

## Requirements
- R1: The PWM code `2'b01` means high. On it the low gate turns off at the next clock edge, or is already off. The high gate turns on after the low-side-off feedback has been seen high for `NOV_CYCLES` consecutive sampled edges. While the code is high, `ls_keep` has no effect: high gate on, low gate off.
- R2: The PWM code `2'b00` with `ls_keep`=1 means low. The high gate turns off at the next edge. The low gate turns on after the high-side-off feedback has been seen high for `NOV_CYCLES` consecutive sampled edges.
- R3: The PWM code `2'b00` with `ls_keep`=0 turns both gates off at the next edge. Neither gate turns on while that command holds.
- R4: The PWM codes `2'b10` and `2'b11` mean mid. Mid with `ls_keep`=1 turns the high gate off at the next edge. The low gate then turns on through the non-overlap path, or at once if it is already on. It stays on for `BLANK_CYCLES`+1 edges, and `sw_zero_cross` is ignored during that window.
- R5: After the blanking window in mid, the low gate turns off at the first edge where `sw_zero_cross` is sampled high. It then stays off while the mid command holds, whatever `sw_zero_cross` does.
- R6: Mid with `ls_keep`=0 turns the low gate off at the next edge, with no blanking and no zero-cross wait.
- R7: `drv_allow`=0 or `ot_fault`=1 turns both gates off at the next edge. On release, a turn-on again goes through the full non-overlap path.
- R8: The high and low gate enables are never both 1 in the same cycle.
- R9: The non-overlap count advances only while the relevant feedback is high. A low feedback sample restarts the count, and feedback held low blocks the turn-on indefinitely.
- R10: A command change during blanking aborts the window. Going to high drops the low gate at the next edge and then runs the R1 sequence. Going to low with `ls_keep`=1 keeps the low gate on with no gap.
- R11: `sw_zero_cross` has no effect outside the mid state.
- R12: During reset and at its release both gate enables are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| pwm_state | input | 2 | Decoded PWM level: 00 low, 01 high, 10/11 mid |
| ls_keep | input | 1 | Low-side keep: 0 drops the low gate in low and mid |
| drv_allow | input | 1 | Active-low disable: 0 forces both gates off |
| ot_fault | input | 1 | Thermal shutdown: 1 forces both gates off |
| hs_gate_off | input | 1 | Feedback: high-side switch has stopped conducting |
| ls_gate_off | input | 1 | Feedback: low-side switch has stopped conducting |
| sw_zero_cross | input | 1 | Switch-node zero-current flag |
| hs_gate_en | output | 1 | High-side gate enable |
| ls_gate_en | output | 1 | Low-side gate enable |

## Verification
The bench models the feedback as the opposite gate delayed by zero, one or two cycles and sweeps every transition for each delay. It counts edges to each turn-on against one plus the feedback delay plus the non-overlap count. A design that started its timer when the turn-off was decided, rather than on feedback, would turn on early at the larger delays. The bench also pulses zero-cross inside the blanking window, aborts blanking in both directions, and glitches the feedback low for one cycle. A design that let the count resume after a glitch, or latched the zero-cross flag early, would show a gate edge at the wrong cycle. Disable and fault are applied in both conduction states to catch a turn-on that skips the non-overlap path after release.

// File: rtl/hbgs_pkg.sv
// Shared types for the half-bridge gate sequencer.
// Assumes: a two-bit decoded PWM level and one FSM state per conduction phase.
package hbgs_pkg;

    typedef enum logic [1:0] {
        PWM_LOW  = 2'b00,
        PWM_HIGH = 2'b01,
        PWM_MID  = 2'b10,
        PWM_MID2 = 2'b11
    } pwm_lvl_t;

    // Conduction request after qualification by enable and fault
    typedef enum logic [1:0] {
        REQ_NONE,
        REQ_HS,
        REQ_LS,
        REQ_DE
    } req_t;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_DT_HS,
        ST_HS,
        ST_DT_LS,
        ST_LS,
        ST_BLANK,
        ST_ZCW,
        ST_DE_OFF
    } seq_st_t;

    function automatic logic st_drives_hs(seq_st_t s);
        return (s == ST_HS);
    endfunction

    function automatic logic st_drives_ls(seq_st_t s);
        return (s == ST_LS) || (s == ST_BLANK) || (s == ST_ZCW);
    endfunction

endpackage

// File: rtl/hbgs_cmd_decode.sv
// Maps the PWM level, low-side keep, enable and fault onto one request.
// Assumes: inputs are already synchronous to clk; purely combinational.
module hbgs_cmd_decode
    import hbgs_pkg::*;
(
    input  logic [1:0] pwm_i,
    input  logic       keep_i,
    input  logic       allow_i,
    input  logic       fault_i,
    output req_t       req_o
);
    pwm_lvl_t lvl;
    assign lvl = pwm_lvl_t'(pwm_i);

    // Request selection: a kill overrides everything, else decode level
    always_comb begin
        if (!allow_i || fault_i) begin
            req_o = REQ_NONE;
        end else begin
            unique case (lvl)
                PWM_HIGH: req_o = REQ_HS;
                PWM_LOW:  req_o = keep_i ? REQ_LS : REQ_NONE;
                default:  req_o = keep_i ? REQ_DE : REQ_NONE;
            endcase
        end
    end
endmodule

// File: rtl/hbgs_phase_timer.sv
// Saturating up-counter shared by the non-overlap and blanking phases.
// Assumes: lim_i >= 1; done_o is high once lim_i-1 cycles have been counted.
module hbgs_phase_timer #(
    parameter int CW = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clr_i,
    input  logic [CW-1:0] lim_i,
    output logic          done_o
);
    logic [CW-1:0] cnt_q;

    assign done_o = (cnt_q == lim_i - 1'b1);

    // Count register: clear on request, hold at the limit
    always_ff @(posedge clk) begin
        if (!rst_n)      cnt_q <= '0;
        else if (clr_i)  cnt_q <= '0;
        else if (!done_o) cnt_q <= cnt_q + 1'b1;
    end
endmodule

// File: rtl/hbgs_gate_fsm.sv
// Conduction sequencer: walks turn-ons through feedback-gated dead time,
// turns off on the deciding edge, and runs mid-level diode emulation.
// Assumes: feedback inputs are high when the named switch is not conducting.
module hbgs_gate_fsm
    import hbgs_pkg::*;
(
    input  logic    clk,
    input  logic    rst_n,
    input  req_t    req_i,
    input  logic    hs_off_i,
    input  logic    ls_off_i,
    input  logic    zc_i,
    input  logic    tmr_done_i,
    output seq_st_t st_o,
    output logic    tmr_clr_o,
    output logic    blank_sel_o
);
    seq_st_t st_q, st_d;

    // Next-state decision per request
    always_comb begin
        st_d = st_q;
        unique case (req_i)
            REQ_NONE: st_d = ST_IDLE;
            REQ_HS: begin
                if (st_q == ST_DT_HS) begin
                    if (ls_off_i && tmr_done_i) st_d = ST_HS;
                end else if (st_q != ST_HS) begin
                    st_d = ST_DT_HS;
                end
            end
            REQ_LS: begin
                unique case (st_q)
                    ST_LS:            st_d = ST_LS;
                    ST_BLANK, ST_ZCW: st_d = ST_LS;
                    ST_DT_LS:         if (hs_off_i && tmr_done_i) st_d = ST_LS;
                    default:          st_d = ST_DT_LS;
                endcase
            end
            REQ_DE: begin
                unique case (st_q)
                    ST_BLANK:  if (tmr_done_i) st_d = ST_ZCW;
                    ST_ZCW:    if (zc_i) st_d = ST_DE_OFF;
                    ST_DE_OFF: st_d = ST_DE_OFF;
                    ST_LS:     st_d = ST_BLANK;
                    ST_DT_LS:  if (hs_off_i && tmr_done_i) st_d = ST_BLANK;
                    default:   st_d = ST_DT_LS;
                endcase
            end
            default: st_d = ST_IDLE;
        endcase
    end

    // Timer control: restart on any phase change or on a low feedback sample
    always_comb begin
        tmr_clr_o = (st_d != st_q)
                 || ((st_q == ST_DT_HS) && !ls_off_i)
                 || ((st_q == ST_DT_LS) && !hs_off_i);
        blank_sel_o = (st_q == ST_BLANK);
    end

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= ST_IDLE;
        else        st_q <= st_d;
    end

    assign st_o = st_q;
endmodule

// File: rtl/hb_gate_sequencer.sv
// Top of the half-bridge gate sequencer: decode, sequencer, phase timer
// and registered-state output decode.
// Assumes: NOV_CYCLES >= 1 and BLANK_CYCLES >= 1; all inputs synchronous.
module hb_gate_sequencer
    import hbgs_pkg::*;
#(
    parameter int NOV_CYCLES   = 3,
    parameter int BLANK_CYCLES = 8
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic [1:0] pwm_state,
    input  logic       ls_keep,
    input  logic       drv_allow,
    input  logic       ot_fault,
    input  logic       hs_gate_off,
    input  logic       ls_gate_off,
    input  logic       sw_zero_cross,
    output logic       hs_gate_en,
    output logic       ls_gate_en
);
    localparam int MAXL = (NOV_CYCLES > BLANK_CYCLES) ? NOV_CYCLES : BLANK_CYCLES;
    localparam int CW   = $clog2(MAXL + 1);
    localparam logic [CW-1:0] NOV_L   = CW'(NOV_CYCLES);
    localparam logic [CW-1:0] BLANK_L = CW'(BLANK_CYCLES);

    req_t          req;
    seq_st_t       st;
    logic          tmr_clr, tmr_done, blank_sel;
    logic [CW-1:0] tmr_lim;

    hbgs_cmd_decode u_dec (
        .pwm_i   (pwm_state),
        .keep_i  (ls_keep),
        .allow_i (drv_allow),
        .fault_i (ot_fault),
        .req_o   (req)
    );

    hbgs_gate_fsm u_fsm (
        .clk         (clk),
        .rst_n       (rst_n),
        .req_i       (req),
        .hs_off_i    (hs_gate_off),
        .ls_off_i    (ls_gate_off),
        .zc_i        (sw_zero_cross),
        .tmr_done_i  (tmr_done),
        .st_o        (st),
        .tmr_clr_o   (tmr_clr),
        .blank_sel_o (blank_sel)
    );

    // Limit select: blanking length in the blanking phase, dead time otherwise
    assign tmr_lim = blank_sel ? BLANK_L : NOV_L;

    hbgs_phase_timer #(.CW(CW)) u_tmr (
        .clk    (clk),
        .rst_n  (rst_n),
        .clr_i  (tmr_clr),
        .lim_i  (tmr_lim),
        .done_o (tmr_done)
    );

    // Gate outputs decoded from the registered state only
    always_comb begin
        hs_gate_en = st_drives_hs(st);
        ls_gate_en = st_drives_ls(st);
    end
endmodule

// File: rtl/hb_gate_sequencer_chk.sv
// Property checker for the gate sequencer, bound onto every instance.
module hb_gate_sequencer_chk (
    input logic       clk,
    input logic       rst_n,
    input logic [1:0] pwm_state,
    input logic       ls_keep,
    input logic       drv_allow,
    input logic       ot_fault,
    input logic       hs_gate_off,
    input logic       ls_gate_off,
    input logic       hs_gate_en,
    input logic       ls_gate_en
);
    // R8
    no_overlap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(hs_gate_en && ls_gate_en));

    // R1
    hs_on_gated_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(hs_gate_en) |-> ($past(ls_gate_off) && !$past(ls_gate_en)));

    // R2
    ls_on_gated_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ls_gate_en) |-> ($past(hs_gate_off) && !$past(hs_gate_en)));

    // R7
    kill_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!drv_allow || ot_fault) |=> (!hs_gate_en && !ls_gate_en));

    // R1
    high_ls_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pwm_state == 2'b01) |=> !ls_gate_en);

    // R3
    low_nokeep_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pwm_state == 2'b00 && !ls_keep) |=> (!hs_gate_en && !ls_gate_en));

    // R6
    mid_nokeep_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pwm_state[1] && !ls_keep) |=> !ls_gate_en);
endmodule

bind hb_gate_sequencer hb_gate_sequencer_chk u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .pwm_state   (pwm_state),
    .ls_keep     (ls_keep),
    .drv_allow   (drv_allow),
    .ot_fault    (ot_fault),
    .hs_gate_off (hs_gate_off),
    .ls_gate_off (ls_gate_off),
    .hs_gate_en  (hs_gate_en),
    .ls_gate_en  (ls_gate_en)
);

// File: tb/hb_gate_sequencer_test.sv
module hb_gate_sequencer_test;
    localparam int CLK_PERIOD = 10;
    localparam int NOV = 2;
    localparam int BLK = 3;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [1:0] pwm_state = 2'b00;
    logic       ls_keep = 1'b0;
    logic       drv_allow = 1'b1;
    logic       ot_fault = 1'b0;
    logic       sw_zero_cross = 1'b0;
    logic       hs_gate_off, ls_gate_off;
    logic       hs_gate_en, ls_gate_en;

    int  fbd = 0;
    bit  force_lo = 1'b0;
    logic [1:0] gh_h = 2'b00, gl_h = 2'b00;
    int  checks = 0, fails = 0;
    bit  finished = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    // Feedback model: opposite gate delayed by fbd cycles
    always @(posedge clk) begin
        gh_h <= {gh_h[0], hs_gate_en};
        gl_h <= {gl_h[0], ls_gate_en};
    end
    always_comb begin
        hs_gate_off = (fbd == 0) ? !hs_gate_en : (fbd == 1) ? !gh_h[0] : !gh_h[1];
        ls_gate_off = !force_lo &&
                      ((fbd == 0) ? !ls_gate_en : (fbd == 1) ? !gl_h[0] : !gl_h[1]);
    end

    hb_gate_sequencer #(.NOV_CYCLES(NOV), .BLANK_CYCLES(BLK)) uut (
        .clk(clk), .rst_n(rst_n), .pwm_state(pwm_state), .ls_keep(ls_keep),
        .drv_allow(drv_allow), .ot_fault(ot_fault), .hs_gate_off(hs_gate_off),
        .ls_gate_off(ls_gate_off), .sw_zero_cross(sw_zero_cross),
        .hs_gate_en(hs_gate_en), .ls_gate_en(ls_gate_en));

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d (fbd=%0d t=%0t)", tag, act, exp, fbd, $time);
        end
    endtask

    task automatic apply(input logic [1:0] c, input logic k);
        @(negedge clk);
        pwm_state = c;
        ls_keep = k;
    endtask

    // Edges until the chosen gate reaches lvl (which: 0 high gate, 1 low gate)
    task automatic wait_sig(input int which, input logic lvl, output int n);
        n = 0;
        do begin
            @(posedge clk); #1;
            n++;
        end while (((which == 0) ? hs_gate_en : ls_gate_en) != lvl && n < 40);
    endtask

    task automatic hold_both(input int cyc, input logic eh, input logic el, input string tag);
        for (int i = 0; i < cyc; i++) begin
            @(posedge clk); #1;
            chk(hs_gate_en == eh && ls_gate_en == el, tag,
                {hs_gate_en, ls_gate_en}, {eh, el});
        end
    endtask

    task automatic settle();
        repeat (12) @(posedge clk);
        #1;
    endtask

    initial begin
        int n;
        repeat (3) @(posedge clk);
        #1;
        chk(!hs_gate_en && !ls_gate_en, "R12 reset", {hs_gate_en, ls_gate_en}, 0);
        @(negedge clk); rst_n = 1'b1;
        @(posedge clk); #1;
        chk(!hs_gate_en && !ls_gate_en, "R12 release", {hs_gate_en, ls_gate_en}, 0);

        for (int d = 0; d < 3; d++) begin
            fbd = d;
            // R2 from idle: feedback already high
            apply(2'b00, 1'b1); wait_sig(1, 1'b1, n);
            chk(n == 1 + NOV, "R2 ls on from idle", n, 1 + NOV);
            settle();
            // R1 from LS
            apply(2'b01, 1'b1);
            @(posedge clk); #1;
            chk(!ls_gate_en, "R1 ls off first edge", ls_gate_en, 0);
            n = 1;
            if (!hs_gate_en) begin wait_sig(0, 1'b1, n); n++; end
            chk(n == 1 + d + NOV, "R1 hs on delay", n, 1 + d + NOV);
            // R1 keep ignored while high
            for (int k = 0; k < 4; k++) begin
                @(negedge clk); ls_keep = k[0];
                @(posedge clk); #1;
                chk(hs_gate_en && !ls_gate_en, "R1 keep ignored", {hs_gate_en, ls_gate_en}, 2);
            end
            // R2 from HS
            apply(2'b00, 1'b1);
            @(posedge clk); #1;
            chk(!hs_gate_en, "R2 hs off first edge", hs_gate_en, 0);
            n = 1;
            if (!ls_gate_en) begin wait_sig(1, 1'b1, n); n++; end
            chk(n == 1 + d + NOV, "R2 ls on delay", n, 1 + d + NOV);
            // R11 zero-cross ignored in low state
            sw_zero_cross = 1'b1;
            hold_both(4, 1'b0, 1'b1, "R11 zc in low");
            // R4 mid from LS: blanking starts at once, zc held high
            apply(2'b10, 1'b1);
            wait_sig(1, 1'b0, n);
            chk(n == BLK + 2, "R4 blank length", n, BLK + 2);
            // R5 stays off in mid
            for (int k = 0; k < 4; k++) begin
                @(negedge clk); sw_zero_cross = k[0];
                @(posedge clk); #1;
                chk(!ls_gate_en && !hs_gate_en, "R5 stays off", ls_gate_en, 0);
            end
            sw_zero_cross = 1'b0;
            // R4 mid from HS through non-overlap, zc pulse in blanking ignored
            apply(2'b01, 1'b1); settle();
            apply(2'b11, 1'b1);
            @(posedge clk); #1;
            chk(!hs_gate_en, "R4 hs off first edge", hs_gate_en, 0);
            n = 1;
            if (!ls_gate_en) begin wait_sig(1, 1'b1, n); n++; end
            chk(n == 1 + d + NOV, "R4 ls on delay", n, 1 + d + NOV);
            sw_zero_cross = 1'b1;
            hold_both(2, 1'b0, 1'b1, "R4 zc ignored in blank");
            sw_zero_cross = 1'b0;
            hold_both(5, 1'b0, 1'b1, "R5 waits for zc");
            @(negedge clk); sw_zero_cross = 1'b1;
            wait_sig(1, 1'b0, n);
            chk(n == 1, "R5 off at zc", n, 1);
            sw_zero_cross = 1'b0;
            // R6 mid without keep
            apply(2'b01, 1'b1); settle();
            apply(2'b10, 1'b1); wait_sig(1, 1'b1, n);
            apply(2'b10, 1'b0); wait_sig(1, 1'b0, n);
            chk(n == 1, "R6 immediate off", n, 1);
            // R10 abort blanking to high
            apply(2'b10, 1'b1); wait_sig(1, 1'b1, n);
            apply(2'b01, 1'b1);
            @(posedge clk); #1;
            chk(!ls_gate_en, "R10 abort ls off", ls_gate_en, 0);
            n = 1;
            if (!hs_gate_en) begin wait_sig(0, 1'b1, n); n++; end
            chk(n == 1 + d + NOV, "R10 hs on delay", n, 1 + d + NOV);
            // R10 abort blanking to low with keep
            apply(2'b10, 1'b1); wait_sig(1, 1'b1, n);
            apply(2'b00, 1'b1);
            sw_zero_cross = 1'b1;
            hold_both(BLK + 4, 1'b0, 1'b1, "R10 ls kept");
            sw_zero_cross = 1'b0;
            // R3 low without keep
            apply(2'b01, 1'b1); settle();
            apply(2'b00, 1'b0);
            hold_both(8, 1'b0, 1'b0, "R3 both off");
            // R7 disable in HS, then restart
            apply(2'b01, 1'b1); settle();
            @(negedge clk); drv_allow = 1'b0;
            hold_both(4, 1'b0, 1'b0, "R7 disable");
            @(negedge clk); drv_allow = 1'b1;
            wait_sig(0, 1'b1, n);
            chk(n == 1 + NOV, "R7 restart delay", n, 1 + NOV);
            // R7 fault in LS
            apply(2'b00, 1'b1); settle();
            @(negedge clk); ot_fault = 1'b1;
            hold_both(4, 1'b0, 1'b0, "R7 fault");
            @(negedge clk); ot_fault = 1'b0;
            wait_sig(1, 1'b1, n);
            chk(n == 1 + NOV, "R7 fault restart", n, 1 + NOV);
            // R9 feedback blocked, glitch, then release
            settle();
            @(negedge clk); force_lo = 1'b1; pwm_state = 2'b01;
            hold_both(10, 1'b0, 1'b0, "R9 blocked");
            @(negedge clk); force_lo = 1'b0;
            @(negedge clk); force_lo = 1'b1;
            hold_both(3, 1'b0, 1'b0, "R9 glitch restart");
            @(negedge clk); force_lo = 1'b0;
            wait_sig(0, 1'b1, n);
            chk(n == NOV, "R9 count after release", n, NOV);
            apply(2'b00, 1'b0); settle();
        end

        finished = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 150000);
        if (!finished) begin
            fails++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end
endmodule